// File: doc/BRIEF.md
# Offset Converter Register Receiver

This block is a write-only two-wire serial slave. It holds the settings of three offset converters and one shared range selector. The system clock samples both bus lines. The block finds start and stop conditions, compares the address byte against its own address, and then takes in data bytes.

Each data byte names its target in its two top bits, so a host may write the registers in any order and may write the same register more than once. A byte takes effect as soon as its eighth bit has been sampled; the block does not wait for the stop condition. Each write also raises a one-cycle strobe for the register it changed. A single transfer may carry at most four data bytes. The block gives no acknowledge to any later byte and discards it.

Top module: `offset_dac_rx`

## Requirements
- R1: The slave answers only the address byte `{4'b1100, chip_sel[1], chip_sel[0], 1'b1, 1'b0}`, which gives 0xC2, 0xC6, 0xCA or 0xCE. It acknowledges that byte by driving `sda_oe` high through the ninth SCL pulse. An address byte with the R/W bit (bit 0) set is not acknowledged.
- R2: When the address does not match, the block gives no acknowledge for that byte or for any following byte, and no register or strobe changes until the next start condition.
- R3: Data byte bits [7:6] choose the target register: 00 is `conv1_code`, 01 is `conv2_code`, 10 is `conv3_code` and 11 is `range_code`. Only the chosen register changes.
- R4: A converter byte stores its bits [5:0] unchanged. Bit 5 is the sign (1 means positive, 0 means negative) and bits [4:0] are the step count.
- R5: A range byte stores its bits [1:0] in `range_code`. Bits [5:2] of that byte have no effect.
- R6: A register and its bit of `upd_strobe` (bit 0 for conv1, bit 1 for conv2, bit 2 for conv3, bit 3 for range) update one system clock after the eighth data bit is sampled, before any stop condition. The strobe lasts exactly one cycle, and at most one strobe bit is high at a time.
- R7: Each transfer accepts and acknowledges at most four data bytes. The fifth and later bytes get no acknowledge and change nothing.
- R8: Repeated writes to one register in a single transfer each raise a strobe, and the last write sets the final value.
- R9: A start, a repeated start or a stop clears the data byte count. After a start or repeated start, the next byte is treated as an address.
- R10: After reset all codes are zero, `upd_strobe` is zero and `sda_oe` is low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| chip_sel | input | 2 | Selects address bits 3 and 2 |
| sda_oe | output | 1 | When high, the data line is pulled low (acknowledge) |
| conv1_code | output | 6 | Sign-magnitude code for converter 1 |
| conv2_code | output | 6 | Sign-magnitude code for converter 2 |
| conv3_code | output | 6 | Sign-magnitude code for converter 3 |
| range_code | output | 2 | Shared step-size selector |
| upd_strobe | output | 4 | One-cycle write pulse, one bit per register |

## Verification
The fourth data byte of a transfer commits its register and fills the byte allowance on the same bus clock edge. The bench provokes this with five-byte transfers. It judges the result by checking that the fourth byte is acknowledged and applied, while the fifth is refused and leaves every register and strobe count unchanged. A repeated start placed just after a commit is also checked: the next byte must be matched as an address, and the transfer must then be granted four fresh data bytes.

// File: rtl/offset_dac_rx.sv
module offset_dac_rx #(
  parameter int MAX_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] chip_sel,
  output logic       sda_oe,
  output logic [5:0] conv1_code,
  output logic [5:0] conv2_code,
  output logic [5:0] conv3_code,
  output logic [1:0] range_code,
  output logic [3:0] upd_strobe
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP} state_t;

  state_t           state;
  logic [2:0]       scl_q, sda_q;
  logic [6:0]       shreg;
  logic [3:0]       bitcnt;
  logic [CNT_W-1:0] nbytes;
  logic             ack_pend;

  wire scl    = scl_q[1];
  wire scl_d  = scl_q[2];
  wire sda    = sda_q[1];
  wire sda_d  = sda_q[2];
  wire rise   = scl & ~scl_d;
  wire fall   = ~scl & scl_d;
  wire start  = scl & scl_d & sda_d & ~sda;
  wire stop   = scl & scl_d & ~sda_d & sda;
  wire [7:0] byte_now = {shreg, sda};
  wire addr_ok = byte_now == {4'b1100, chip_sel, 2'b10};
  wire active  = (state == ST_ADDR) || (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      nbytes     <= '0;
      ack_pend   <= 1'b0;
      sda_oe     <= 1'b0;
      conv1_code <= '0;
      conv2_code <= '0;
      conv3_code <= '0;
      range_code <= '0;
      upd_strobe <= '0;
    end else begin
      upd_strobe <= '0;
      if (start || stop) begin
        state    <= start ? ST_ADDR : ST_IDLE;
        bitcnt   <= '0;
        nbytes   <= '0;
        ack_pend <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        if (fall) begin
          sda_oe <= (bitcnt == 4'd8) && ack_pend;
          if (bitcnt == 4'd8) ack_pend <= 1'b0;
        end
        if (rise && active) begin
          if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (state == ST_DATA && nbytes == CNT_W'(MAX_BYTES)) state <= ST_SKIP;
          end else begin
            shreg  <= byte_now[6:0];
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              if (state == ST_ADDR) begin
                if (addr_ok) begin
                  ack_pend <= 1'b1;
                  state    <= ST_DATA;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                ack_pend <= 1'b1;
                nbytes   <= nbytes + 1'b1;
                case (byte_now[7:6])
                  2'b00: begin conv1_code <= byte_now[5:0]; upd_strobe <= 4'b0001; end
                  2'b01: begin conv2_code <= byte_now[5:0]; upd_strobe <= 4'b0010; end
                  2'b10: begin conv3_code <= byte_now[5:0]; upd_strobe <= 4'b0100; end
                  default: begin range_code <= byte_now[1:0]; upd_strobe <= 4'b1000; end
                endcase
              end
            end
          end
        end
      end
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_strobe));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_strobe) |=> (upd_strobe == 4'b0000));

  p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe == 4'b0000) |-> $stable({conv1_code, conv2_code, conv3_code, range_code}));

  p_byte_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nbytes <= CNT_W'(MAX_BYTES));

  p_ack_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);

  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |=> (upd_strobe == 4'b0000));

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!sda_oe && nbytes == '0));
endmodule

// File: tb/tb_offset_dac_rx.sv
module tb_offset_dac_rx;
  localparam int CLK_PERIOD = 10;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] chip_sel = 2'b00;
  logic sda_oe;
  logic [5:0] conv1_code, conv2_code, conv3_code;
  logic [1:0] range_code;
  logic [3:0] upd_strobe;
  wire sda_line = m_sda & ~sda_oe;

  int errors = 0;
  int checks = 0;
  int stb_cnt [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  offset_dac_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .chip_sel(chip_sel), .sda_oe(sda_oe),
    .conv1_code(conv1_code), .conv2_code(conv2_code), .conv3_code(conv3_code),
    .range_code(range_code), .upd_strobe(upd_strobe)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) stb_cnt[i] <= 0;
    end else begin
      for (int i = 0; i < 4; i++) if (upd_strobe[i]) stb_cnt[i] <= stb_cnt[i] + 1;
    end
  end

  // byte, conv1, conv2, conv3, range expected after the single-byte transfer
  localparam logic [27:0] VEC [6] = '{
    {8'h25, 6'h25, 6'h00, 6'h00, 2'd0},
    {8'h5F, 6'h25, 6'h1F, 6'h00, 2'd0},
    {8'hA0, 6'h25, 6'h1F, 6'h20, 2'd0},
    {8'hFE, 6'h25, 6'h1F, 6'h20, 2'd2},
    {8'h3F, 6'h3F, 6'h1F, 6'h20, 2'd2},
    {8'hC1, 6'h3F, 6'h1F, 6'h20, 2'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic hwait();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hwait(); m_scl = 1'b1; hwait(); m_sda = 1'b0; hwait(); m_scl = 1'b0; hwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hwait(); m_scl = 1'b1; hwait(); m_sda = 1'b1; hwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hwait(); m_scl = 1'b1; hwait(); m_scl = 1'b0;
    end
    m_sda = 1'b1; hwait(); m_scl = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = !sda_line;
    repeat (H/2) @(negedge clk);
    m_scl = 1'b0; hwait();
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    bit ack;
    int s0, s2;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk_eq("R10 conv1 reset", conv1_code, 0);
    chk_eq("R10 conv2 reset", conv2_code, 0);
    chk_eq("R10 conv3 reset", conv3_code, 0);
    chk_eq("R10 range reset", range_code, 0);
    chk_eq("R10 sda_oe reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_eq("R10 strobe idle", upd_strobe, 0);

    // R3 R4 R5 table of single-byte writes
    for (int v = 0; v < 6; v++) begin
      bus_start();
      send_byte(8'hC2, ack);
      chk_eq("R1 address ack", ack, 1);
      send_byte(VEC[v][27:20], ack);
      chk_eq("R3 data ack", ack, 1);
      bus_stop();
      chk_eq("R4 conv1 value", conv1_code, VEC[v][19:14]);
      chk_eq("R4 conv2 value", conv2_code, VEC[v][13:8]);
      chk_eq("R4 conv3 value", conv3_code, VEC[v][7:2]);
      chk_eq("R5 range value", range_code, VEC[v][1:0]);
    end
    chk_eq("R3 strobe count conv1", stb_cnt[0], 2);
    chk_eq("R3 strobe count range", stb_cnt[3], 2);

    // R1 other chip select
    chip_sel = 2'b10;
    bus_start();
    send_byte(8'hCA, ack);
    chk_eq("R1 address CA ack", ack, 1);
    send_byte(8'h05, ack);
    bus_stop();
    chk_eq("R1 conv1 via CA", conv1_code, 6'h05);

    // R2 mismatched address ignored
    s0 = stb_cnt[1];
    bus_start();
    send_byte(8'hC2, ack);
    chk_eq("R2 wrong address nack", ack, 0);
    send_byte(8'h4A, ack);
    chk_eq("R2 data after mismatch nack", ack, 0);
    bus_stop();
    chk_eq("R2 conv2 unchanged", conv2_code, 6'h1F);
    chk_eq("R2 no strobe", stb_cnt[1], s0);

    // R1 read bit set
    bus_start();
    send_byte(8'hCB, ack);
    chk_eq("R1 read address nack", ack, 0);
    bus_stop();

    // R6 commit before stop
    chip_sel = 2'b00;
    s2 = stb_cnt[2];
    bus_start();
    send_byte(8'hC2, ack);
    send_byte(8'h8A, ack);
    chk_eq("R6 conv3 before stop", conv3_code, 6'h0A);
    chk_eq("R6 strobe before stop", stb_cnt[2], s2 + 1);
    bus_stop();

    // R7 R8 cap and last write wins
    s0 = stb_cnt[0];
    bus_start();
    send_byte(8'hC2, ack);
    send_byte(8'h01, ack); chk_eq("R7 byte1 ack", ack, 1);
    send_byte(8'h02, ack); chk_eq("R7 byte2 ack", ack, 1);
    send_byte(8'h03, ack); chk_eq("R7 byte3 ack", ack, 1);
    send_byte(8'h04, ack); chk_eq("R7 byte4 ack", ack, 1);
    send_byte(8'h7F, ack); chk_eq("R7 byte5 nack", ack, 0);
    bus_stop();
    chk_eq("R8 last write wins", conv1_code, 6'h04);
    chk_eq("R8 four strobes", stb_cnt[0], s0 + 4);
    chk_eq("R7 fifth byte dropped", conv2_code, 6'h1F);

    // R9 repeated start resets count
    bus_start();
    send_byte(8'hC2, ack);
    send_byte(8'h41, ack);
    send_byte(8'h42, ack);
    send_byte(8'h43, ack);
    bus_start();
    send_byte(8'hC2, ack); chk_eq("R9 address after repstart", ack, 1);
    send_byte(8'h81, ack);
    send_byte(8'h82, ack);
    send_byte(8'h83, ack);
    send_byte(8'hC3, ack); chk_eq("R9 fourth after repstart ack", ack, 1);
    bus_stop();
    chk_eq("R9 conv2", conv2_code, 6'h03);
    chk_eq("R9 conv3", conv3_code, 6'h03);
    chk_eq("R9 range", range_code, 2'd3);

    // R9 stop resets count
    bus_start();
    send_byte(8'hC2, ack);
    send_byte(8'h11, ack);
    send_byte(8'h12, ack);
    send_byte(8'h13, ack);
    bus_stop();
    bus_start();
    send_byte(8'hC2, ack);
    send_byte(8'h21, ack);
    send_byte(8'h22, ack);
    send_byte(8'h23, ack);
    send_byte(8'h24, ack); chk_eq("R9 fourth after stop ack", ack, 1);
    bus_stop();
    chk_eq("R9 conv1 after stop", conv1_code, 6'h24);

    // R10 reset mid-run
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R10 conv1 after reset", conv1_code, 0);
    chk_eq("R10 range after reset", range_code, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule